// File: doc/BRIEF.md
# Program Memory Table Access Guard

This block sits between the table-read/table-write path of a processor and a 32 KB program memory. The memory is split into a 2 KB boot block followed by four user blocks. On every access the guard receives the pointer address being read or written, the program counter of the instruction making the access, and whether it is a read or a write. It then decides whether the write may reach the array, or whether the read data is passed through or replaced by zeros. A refused access never raises a fault. A refused write is only flagged, and a refused read quietly returns zero.

Each block has two protection bits: a write-protect bit and a read-protect bit. In both, 0 means the protection is active. Normal configuration writes can only move a bit from 1 to 0. A bit returns to 1 only through an erase request, which is either a block erase for one block or a full erase for all of them. All decisions use the protection state held before the current cycle's configuration change. Results appear one clock after the request.

Top module: `flash_guard`

## Requirements
- R1: Target and program counter addresses decode to blocks as follows. Boot block (index 0) is 000000h–0007FFh. User block 0 (index 1) is 000800h–001FFFh. User blocks 1, 2 and 3 (indexes 2, 3, 4) are 002000h–003FFFh, 004000h–005FFFh and 006000h–007FFFh. `cfg_idx` uses these indexes.
- R2: A write (`acc_write`=1) whose target block has write-protect 0 is refused whatever the program counter: `arr_we`=0 and `wr_blocked`=1 in the next cycle.
- R3: A write whose target block has write-protect 1 gives `arr_we`=1 and `wr_blocked`=0 in the next cycle.
- R4: A read (`acc_write`=0) whose target block has read-protect 0 returns `rd_raw` only when the program counter lies in that same block. Otherwise it returns all zeros. Both cases complete without any flag.
- R5: A read whose target block has read-protect 1 returns `rd_raw` from any program counter.
- R6: Targets at 008000h and above are not checked: writes are enabled and reads pass through.
- R7: A configuration write (`cfg_wr`) ANDs `cfg_wp`/`cfg_rp` into the bits of block `cfg_idx`. Writing 1 over 0 has no effect.
- R8: A block erase (`erase_blk`) sets both bits of block `cfg_idx` to 1 and leaves the other blocks unchanged. It takes priority over `cfg_wr`.
- R9: A full erase (`erase_all`) sets every protection bit to 1.
- R10: After reset every protection bit is 1, so all accesses are allowed.
- R11: Outputs are registered with one cycle of latency. A cycle with `acc_valid`=0 yields `arr_we`=0, `wr_blocked`=0 and `rd_data`=0. A write yields `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| acc_addr | input | 22 | Target pointer address |
| acc_pc | input | 22 | Program counter of the issuing instruction |
| rd_raw | input | 8 | Data read from the array |
| cfg_wr | input | 1 | Protection configuration write |
| cfg_idx | input | 3 | Block index for configuration write or block erase |
| cfg_wp | input | 1 | Write-protect value (ANDed in) |
| cfg_rp | input | 1 | Read-protect value (ANDed in) |
| erase_blk | input | 1 | Block erase of block `cfg_idx` |
| erase_all | input | 1 | Full erase of all protection bits |
| arr_we | output | 1 | Write enable to the array |
| rd_data | output | 8 | Filtered read data |
| wr_blocked | output | 1 | Write refused by protection |

## Verification
The main sweep applies 32 protection patterns, one for each 5-bit mask. Write and read protection are placed on different blocks so the two bits cannot be confused. Under each pattern it issues every combination of the 12 targets and the 12 program counters, as both read and write. The targets are the first and last address of each block plus two addresses beyond user memory. The first/last pairs separate correct block boundaries from off-by-one decoding. The same-block versus other-block program counters separate read protection from write protection, and the out-of-range addresses show that unchecked space stays open. Separate sequences then try writing 1 over 0, erasing a single block among fully protected ones, a full erase, and idle cycles.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  typedef struct packed {
    logic ok;
    logic flag;
  } verdict_t;
endpackage

// File: rtl/fg_region_decode.sv
module fg_region_decode #(
  parameter int ADDR_W    = 22,
  parameter int NUM_USER  = 4,
  parameter int BOOT_SIZE = 2048,
  parameter int BLK_SIZE  = 8192,
  localparam int NUM_BLK  = NUM_USER + 1,
  localparam int IDX_W    = $clog2(NUM_BLK)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_mem,
  output logic [IDX_W-1:0]  idx
);
  localparam int BLK_SH = $clog2(BLK_SIZE);
  localparam logic [ADDR_W-1:0] MEM_END  = ADDR_W'(BLK_SIZE * NUM_USER);
  localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(BOOT_SIZE);

  logic [ADDR_W-1:0] blk_num;

  always_comb begin
    blk_num = addr >> BLK_SH;
    in_mem  = (addr < MEM_END);
    if (addr < BOOT_END) idx = '0;
    else                 idx = IDX_W'(blk_num + ADDR_W'(1));
  end

  // R1: an in-memory address never maps past the last block
  always_comb begin
    if (in_mem) begin
      p_idx_range_r1: assert (idx < IDX_W'(NUM_BLK));
    end
  end
endmodule

// File: rtl/fg_prot_store.sv
module fg_prot_store #(
  parameter int NUM_USER = 4,
  localparam int NUM_BLK = NUM_USER + 1,
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_wp,
  input  logic               cfg_rp,
  input  logic               erase_blk,
  input  logic               erase_all,
  output logic [NUM_BLK-1:0] wp_q,
  output logic [NUM_BLK-1:0] rp_q
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic hit;
    assign hit = (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || erase_all || (erase_blk && hit)) begin
        wp_q[i] <= 1'b1;
        rp_q[i] <= 1'b1;
      end else if (cfg_wr && hit) begin
        wp_q[i] <= wp_q[i] & cfg_wp;
        rp_q[i] <= rp_q[i] & cfg_rp;
      end
    end
  end

  // R7: without an erase no bit can rise
  p_clear_only_r7: assert property (@(posedge clk) disable iff (rst)
    (!erase_all && !erase_blk) |=>
      (((wp_q & ~$past(wp_q)) == '0) && ((rp_q & ~$past(rp_q)) == '0)));

  // R9: full erase restores every bit
  p_erase_all_r9: assert property (@(posedge clk) disable iff (rst)
    erase_all |=> ((&wp_q) && (&rp_q)));

  // R8: block erase restores the addressed block
  p_erase_blk_r8: assert property (@(posedge clk) disable iff (rst)
    (erase_blk && (cfg_idx < IDX_W'(NUM_BLK))) |=>
      (wp_q[$past(cfg_idx)] && rp_q[$past(cfg_idx)]));
endmodule

// File: rtl/fg_access_check.sv
module fg_access_check
  import fg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_USER = 4,
  localparam int NUM_BLK = NUM_USER + 1,
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               valid,
  input  acc_kind_e          kind,
  input  logic               tgt_in,
  input  logic [IDX_W-1:0]   tgt_idx,
  input  logic               pc_in,
  input  logic [IDX_W-1:0]   pc_idx,
  input  logic [NUM_BLK-1:0] wp,
  input  logic [NUM_BLK-1:0] rp,
  input  logic [DATA_W-1:0]  raw,
  output logic               we_n,
  output logic               blocked_n,
  output logic [DATA_W-1:0]  data_n
);
  logic     sel_wp, sel_rp, same_blk;
  verdict_t wr_v, rd_v;

  always_comb begin
    sel_wp = 1'b1;
    sel_rp = 1'b1;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (tgt_idx == IDX_W'(i)) begin
        sel_wp = wp[i];
        sel_rp = rp[i];
      end
    end
    same_blk = pc_in && tgt_in && (pc_idx == tgt_idx);

    wr_v.ok   = !tgt_in || sel_wp;
    wr_v.flag = !wr_v.ok;
    rd_v.ok   = !tgt_in || sel_rp || same_blk;
    rd_v.flag = 1'b0;

    we_n      = valid && (kind == ACC_WRITE) && wr_v.ok;
    blocked_n = valid && (kind == ACC_WRITE) && wr_v.flag;
    data_n    = (valid && (kind == ACC_READ) && rd_v.ok) ? raw : '0;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 8,
  parameter int NUM_USER  = 4,
  parameter int BOOT_SIZE = 2048,
  parameter int BLK_SIZE  = 8192,
  localparam int NUM_BLK  = NUM_USER + 1,
  localparam int IDX_W    = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] acc_pc,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_wp,
  input  logic              cfg_rp,
  input  logic              erase_blk,
  input  logic              erase_all,
  output logic              arr_we,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_blocked
);
  logic               tgt_in, pc_in;
  logic [IDX_W-1:0]   tgt_idx, pc_idx;
  logic [NUM_BLK-1:0] wp_q, rp_q;
  logic               we_n, blocked_n;
  logic [DATA_W-1:0]  data_n;
  acc_kind_e          kind;

  assign kind = acc_write ? ACC_WRITE : ACC_READ;

  fg_region_decode #(.ADDR_W(ADDR_W), .NUM_USER(NUM_USER),
                     .BOOT_SIZE(BOOT_SIZE), .BLK_SIZE(BLK_SIZE)) u_tgt_dec (
    .addr(acc_addr), .in_mem(tgt_in), .idx(tgt_idx));

  fg_region_decode #(.ADDR_W(ADDR_W), .NUM_USER(NUM_USER),
                     .BOOT_SIZE(BOOT_SIZE), .BLK_SIZE(BLK_SIZE)) u_pc_dec (
    .addr(acc_pc), .in_mem(pc_in), .idx(pc_idx));

  fg_prot_store #(.NUM_USER(NUM_USER)) u_store (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wp(cfg_wp), .cfg_rp(cfg_rp), .erase_blk(erase_blk),
    .erase_all(erase_all), .wp_q(wp_q), .rp_q(rp_q));

  fg_access_check #(.DATA_W(DATA_W), .NUM_USER(NUM_USER)) u_check (
    .valid(acc_valid), .kind(kind), .tgt_in(tgt_in), .tgt_idx(tgt_idx),
    .pc_in(pc_in), .pc_idx(pc_idx), .wp(wp_q), .rp(rp_q), .raw(rd_raw),
    .we_n(we_n), .blocked_n(blocked_n), .data_n(data_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we     <= 1'b0;
      wr_blocked <= 1'b0;
      rd_data    <= '0;
    end else begin
      arr_we     <= we_n;
      wr_blocked <= blocked_n;
      rd_data    <= data_n;
    end
  end

  // R11: an idle cycle produces quiet outputs one cycle later
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!arr_we && !wr_blocked && (rd_data == '0)));

  // R3: array write enable only follows a requested write
  p_we_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(acc_valid && acc_write));

  // R2: a write is either enabled or refused, never both
  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && wr_blocked));

  // R2: a refused write carries no read data
  p_blocked_nodata_r2: assert property (@(posedge clk) disable iff (rst)
    wr_blocked |-> (rd_data == '0));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [21:0] acc_addr, acc_pc;
  logic [7:0]  rd_raw;
  logic        cfg_wr, cfg_wp, cfg_rp, erase_blk, erase_all;
  logic [2:0]  cfg_idx;
  logic        arr_we, wr_blocked;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit mwp[5];
  bit mrp[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_pc(acc_pc), .rd_raw(rd_raw), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_wp(cfg_wp), .cfg_rp(cfg_rp), .erase_blk(erase_blk),
    .erase_all(erase_all), .arr_we(arr_we), .rd_data(rd_data),
    .wr_blocked(wr_blocked));

  // R1: probe addresses, first and last of each block plus two beyond memory
  function automatic logic [21:0] addr_of(input int t);
    case (t)
      0: return 22'h000000;  1: return 22'h0007FF;
      2: return 22'h000800;  3: return 22'h001FFF;
      4: return 22'h002000;  5: return 22'h003FFF;
      6: return 22'h004000;  7: return 22'h005FFF;
      8: return 22'h006000;  9: return 22'h007FFF;
      10: return 22'h008000; default: return 22'h3FFFFF;
    endcase
  endfunction

  // R1: block index from the map; 5 means outside user memory
  function automatic int blk_of(input logic [21:0] a);
    if (a < 22'h000800) return 0;
    if (a < 22'h002000) return 1;
    if (a < 22'h008000) return int'(a >> 13) + 1;
    return 5;
  endfunction

  task automatic check3(input string tag, input bit we, input bit bl, input logic [7:0] d);
    checks++;
    if (arr_we !== we || wr_blocked !== bl || rd_data !== d) begin
      errors++;
      $display("FAIL %s: got we=%b blk=%b data=%h, expected we=%b blk=%b data=%h",
               tag, arr_we, wr_blocked, rd_data, we, bl, d);
    end
  endtask

  task automatic access(input int t, input int p, input bit wr, input string pre);
    logic [21:0] a = addr_of(t);
    logic [21:0] pc = addr_of(p);
    logic [7:0]  raw = 8'((t * 12 + p) % 255 + 1);
    int tb = blk_of(a);
    bit ok;
    string tag;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_pc = pc; rd_raw = raw;
    @(negedge clk);
    if (wr) begin
      ok = (tb == 5) || mwp[tb];
      tag = (tb == 5) ? "R6 write" : (ok ? "R3 write" : "R2 write");
      check3({pre, " R1 ", tag}, ok, !ok, 8'h00);
    end else begin
      ok = (tb == 5) || mrp[tb] || (blk_of(pc) == tb);
      tag = (tb == 5) ? "R6 read" : (mrp[tb] ? "R5 read" : "R4 read");
      check3({pre, " R1 ", tag}, 1'b0, 1'b0, ok ? raw : 8'h00);
    end
  endtask

  task automatic cfg(input int i, input bit w, input bit r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 3'(i); cfg_wp = w; cfg_rp = r;
    @(negedge clk);
    cfg_wr = 1'b0;
    mwp[i] = mwp[i] & w;
    mrp[i] = mrp[i] & r;
  endtask

  task automatic erase_one(input int i);
    @(negedge clk);
    erase_blk = 1'b1; cfg_idx = 3'(i);
    @(negedge clk);
    erase_blk = 1'b0;
    mwp[i] = 1'b1; mrp[i] = 1'b1;
  endtask

  task automatic erase_full();
    @(negedge clk);
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    for (int i = 0; i < 5; i++) begin mwp[i] = 1'b1; mrp[i] = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_pc = '0;
    rd_raw = '0; cfg_wr = 1'b0; cfg_idx = '0; cfg_wp = 1'b1; cfg_rp = 1'b1;
    erase_blk = 1'b0; erase_all = 1'b0;
    for (int i = 0; i < 5; i++) begin mwp[i] = 1'b1; mrp[i] = 1'b1; end
    repeat (3) @(negedge clk);
    check3("R10 reset outputs", 1'b0, 1'b0, 8'h00);
    rst = 1'b0;

    // R10: everything open after reset, accessed from an outside program counter
    for (int t = 0; t < 12; t++) begin
      access(t, 11, 1'b1, "R10");
      access(t, 11, 1'b0, "R10");
    end

    // main sweep over 32 protection patterns
    for (int m = 0; m < 32; m++) begin
      erase_full();
      for (int i = 0; i < 5; i++) cfg(i, m[i], m[(i + 2) % 5]);
      for (int t = 0; t < 12; t++)
        for (int p = 0; p < 12; p++) begin
          access(t, p, 1'b1, "sweep");
          access(t, p, 1'b0, "sweep");
        end
    end

    // R7: writing 1 over 0 has no effect
    erase_full();
    cfg(1, 1'b0, 1'b0);
    cfg(1, 1'b1, 1'b1);
    access(2, 11, 1'b1, "R7");
    access(3, 0, 1'b0, "R7");
    access(3, 2, 1'b0, "R7");

    // R8: block erase of user block 2 only, everything else stays protected
    for (int i = 0; i < 5; i++) cfg(i, 1'b0, 1'b0);
    erase_one(3);
    for (int t = 0; t < 12; t++) begin
      access(t, 11, 1'b1, "R8");
      access(t, 11, 1'b0, "R8");
    end

    // R9: full erase reopens every block
    erase_full();
    for (int t = 0; t < 12; t++) access(t, 11, 1'b1, "R9");

    // R11: idle cycle with a write pattern on the pins
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 22'h000800; rd_raw = 8'hFF;
    @(negedge clk);
    check3("R11 idle", 1'b0, 1'b0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule